// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE 754 operands and records the one-bit outcome in a selectable condition-code bit of a 32-bit floating-point control/status register. The register is held inside the block. It has a read port that is always visible and a write port for software loads.

Each compare takes one of three formats:
- single, using the low 32 bits of each operand;
- double, using all 64 bits;
- paired-single, where the two 32-bit halves are evaluated as independent lanes.

A 3-bit predicate mask selects which outcomes make the condition true: unordered, equal and less. A signal-on-quiet-NaN option turns a quiet-NaN operand into an invalid-operation event instead of a condition write.

Every compare first clears the register's cause field. The control is a two-state machine:
- **IDLE** waits for `op_valid`. The transition IDLE→COMMIT captures the operands and controls.
- **COMMIT** writes the register and raises `op_done`. The transition COMMIT→IDLE is unconditional.

Top module: `fpcc_unit`

## Requirements
- R1: After reset the register reads 0 and `op_done` is 0.
- R2: `op_valid` sampled in IDLE makes the register change, with `op_done` high for exactly one cycle, at the second rising edge after the sampling edge. `op_valid` sampled in COMMIT is ignored.
- R3: Every compare clears register bits 17:12, except that bit 16 is set again on an invalid event. It leaves bits 31:24 (other than condition-code writes), bits 22:18 and bits 11:0 unchanged, apart from bit 6 on an invalid event.
- R4: For two ordered operands, the condition is (`op_pred[1]` AND equal) OR (`op_pred[0]` AND less), compared by numeric value. +0 and −0 are equal.
- R5: When either operand of a lane is a NaN (exponent all ones, fraction nonzero) and no invalid event is taken, the condition equals `op_pred[2]`.
- R6: When `op_sig` is 1 and either operand of a lane is a quiet NaN (top fraction bit 1), bits 16 and 6 are set and that lane writes no condition bit. Bit 6 is never cleared by a compare.
- R7: Condition index 0 writes register bit 23, and index k (1..7) writes bit 24+k.
- R8: `op_fmt` 0 is single: bits 63:32 are ignored and 8/23 exponent/fraction fields are used. `op_fmt` 1 is double, with 11/52 fields. `op_fmt` 3 is reserved and only clears the cause field.
- R9: `op_fmt` 2 is paired-single. Bits 31:0 form lane 0, which writes index `op_cc`. Bits 63:32 form lane 1, which writes index `op_cc`+1 modulo 8. An invalid event in one lane suppresses only that lane's write.
- R10: `csr_we` loads `csr_wdata` into the register at the next edge, except at a COMMIT edge, where the compare result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Compare request strobe |
| op_fmt | input | 2 | Format: 0 single, 1 double, 2 paired-single, 3 reserved |
| op_pred | input | 3 | Predicate mask {unordered, equal, less} |
| op_sig | input | 1 | Treat quiet NaN as invalid |
| op_cc | input | 3 | Condition-code index |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| csr_we | input | 1 | Register write enable |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register contents |
| op_done | output | 1 | Compare committed this cycle |

## Verification
Both single and double are swept over every ordered pair drawn from eleven operands, under all eight predicate masks and both signal settings:
- The operands are both zeros, a denormal, ±1, ±2, ±infinity, a quiet NaN and a signaling NaN.
- The zeros and the denormal separate true equality from bit equality and from magnitude-only ordering.
- The two NaN kinds separate the unordered path from the invalid path.

Paired-single runs pair different operands in the two lanes, so that one lane can signal while the other writes. A random-looking register preload before each compare exposes any stray bit written outside the cause, invalid and condition positions. Directed runs cover:
- each condition index;
- junk in the upper half of single operands;
- the reserved format;
- a strobe and a register write arriving during COMMIT.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
    localparam int CSR_W    = 32;
    localparam int CC_BITS  = 3;
    localparam int CAUSE_HI = 17;
    localparam int CAUSE_LO = 12;
    localparam int CAUSE_V  = 16;
    localparam int FLAG_V   = 6;
    localparam int CC0_POS  = 23;
    localparam int CCN_BASE = 24;
    localparam int SP_EXP   = 8;
    localparam int SP_MAN   = 23;
    localparam int DP_EXP   = 11;
    localparam int DP_MAN   = 52;
    localparam int SP_W     = 1 + SP_EXP + SP_MAN;
    localparam int DP_W     = 1 + DP_EXP + DP_MAN;
    localparam int PS_LANES = DP_W / SP_W;

    typedef enum logic [1:0] {
        FMT_SGL = 2'd0,
        FMT_DBL = 2'd1,
        FMT_PSG = 2'd2,
        FMT_RSV = 2'd3
    } fmt_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } state_e;

    function automatic logic [4:0] cc_pos(input logic [CC_BITS-1:0] idx);
        if (idx == '0) return 5'(CC0_POS);
        return 5'(CCN_BASE) + 5'(idx);
    endfunction
endpackage

// File: rtl/fpcc_lane.sv
module fpcc_lane #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   pred,
    input  logic         sig,
    output logic         sig_hit,
    output logic         cond
);
    logic         a_nan, b_nan, a_qnan, b_qnan;
    logic [W-2:0] a_mag, b_mag;
    logic         zeros, eq, lt;

    always_comb begin
        a_mag  = a[W-2:0];
        b_mag  = b[W-2:0];
        a_nan  = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
        b_nan  = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
        a_qnan = a_nan && a[MAN_W-1];
        b_qnan = b_nan && b[MAN_W-1];
        zeros  = (a_mag == '0) && (b_mag == '0);
        eq     = (a == b) || zeros;
        if (zeros)
            lt = 1'b0;
        else if (a[W-1] != b[W-1])
            lt = a[W-1];
        else if (!a[W-1])
            lt = a_mag < b_mag;
        else
            lt = a_mag > b_mag;
        sig_hit = sig && (a_qnan || b_qnan);
        if (a_nan || b_nan)
            cond = pred[2];
        else
            cond = (pred[1] && eq) || (pred[0] && lt);
    end
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
    import fpcc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [1:0]           op_fmt,
    input  logic [2:0]           op_pred,
    input  logic                 op_sig,
    input  logic [CC_BITS-1:0]   op_cc,
    input  logic [DP_W-1:0]      op_a,
    input  logic [DP_W-1:0]      op_b,
    input  logic                 csr_we,
    input  logic [CSR_W-1:0]     csr_wdata,
    output logic [CSR_W-1:0]     csr_rdata,
    output logic                 op_done
);
    state_e               state_q, state_d;
    fmt_e                 fmt_q;
    logic [2:0]           pred_q;
    logic                 sig_q;
    logic [CC_BITS-1:0]   cc_q;
    logic [DP_W-1:0]      a_q, b_q;
    logic [CSR_W-1:0]     fcsr_q, fcsr_nxt;
    logic                 done_q;
    logic                 busy;

    logic                 dbl_hit, dbl_cond;
    logic [PS_LANES-1:0]  sl_hit, sl_cond;
    logic [PS_LANES-1:0]  wr_en, wr_val;
    logic                 inv;

    assign busy = (state_q == ST_COMMIT);

    fpcc_lane #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_dbl (
        .a(a_q), .b(b_q), .pred(pred_q), .sig(sig_q),
        .sig_hit(dbl_hit), .cond(dbl_cond)
    );

    for (genvar g = 0; g < PS_LANES; g++) begin : g_sl
        fpcc_lane #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_sl (
            .a(a_q[g*SP_W +: SP_W]), .b(b_q[g*SP_W +: SP_W]),
            .pred(pred_q), .sig(sig_q),
            .sig_hit(sl_hit[g]), .cond(sl_cond[g])
        );
    end

    // lane selection per format
    always_comb begin
        wr_en  = '0;
        wr_val = '0;
        inv    = 1'b0;
        unique case (fmt_q)
            FMT_SGL: begin
                wr_en[0]  = !sl_hit[0];
                wr_val[0] = sl_cond[0];
                inv       = sl_hit[0];
            end
            FMT_DBL: begin
                wr_en[0]  = !dbl_hit;
                wr_val[0] = dbl_cond;
                inv       = dbl_hit;
            end
            FMT_PSG: begin
                wr_en  = ~sl_hit;
                wr_val = sl_cond;
                inv    = |sl_hit;
            end
            FMT_RSV: begin
                inv = 1'b0;
            end
        endcase
    end

    // register update for a committed compare
    always_comb begin
        fcsr_nxt = fcsr_q;
        fcsr_nxt[CAUSE_HI:CAUSE_LO] = '0;
        if (inv) begin
            fcsr_nxt[CAUSE_V] = 1'b1;
            fcsr_nxt[FLAG_V]  = 1'b1;
        end
        for (int l = 0; l < PS_LANES; l++) begin
            if (wr_en[l])
                fcsr_nxt[cc_pos(cc_q + CC_BITS'(l))] = wr_val[l];
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (op_valid) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= FMT_SGL;
            pred_q <= '0;
            sig_q  <= 1'b0;
            cc_q   <= '0;
            a_q    <= '0;
            b_q    <= '0;
        end else if (state_q == ST_IDLE && op_valid) begin
            fmt_q  <= fmt_e'(op_fmt);
            pred_q <= op_pred;
            sig_q  <= op_sig;
            cc_q   <= op_cc;
            a_q    <= op_a;
            b_q    <= op_b;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcsr_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= busy;
            if (busy)        fcsr_q <= fcsr_nxt;
            else if (csr_we) fcsr_q <= csr_wdata;
        end
    end

    assign csr_rdata = fcsr_q;
    assign op_done   = done_q;
endmodule

// File: rtl/fpcc_unit_chk.sv
module fpcc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic        busy,
    input logic        op_done,
    input logic        csr_we,
    input logic [31:0] csr_wdata,
    input logic [31:0] csr_rdata
);
    assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> ##1 op_done);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    assert_cause_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> ((csr_rdata[17:12] & 6'b101111) == 6'b0));

    assert_low_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (csr_rdata[11:7] == $past(csr_rdata[11:7]) &&
                     csr_rdata[5:0]  == $past(csr_rdata[5:0])));

    assert_flag_follows_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && csr_rdata[16]) |-> csr_rdata[6]);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && $past(csr_rdata[6])) |-> csr_rdata[6]);

    assert_csr_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && !busy) |=> (csr_rdata == $past(csr_wdata)));
endmodule

bind fpcc_unit fpcc_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .busy(busy),
    .op_done(op_done), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata)
);

// File: tb/fpcc_unit_tb.sv
module fpcc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_fmt = 2'd0;
    logic [2:0]  op_pred = 3'd0;
    logic        op_sig = 1'b0;
    logic [2:0]  op_cc = 3'd0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        op_done;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    fpcc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_fmt(op_fmt),
        .op_pred(op_pred), .op_sig(op_sig), .op_cc(op_cc), .op_a(op_a),
        .op_b(op_b), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .op_done(op_done)
    );

    // operand table: 0 +0, 1 -0, 2 denorm, 3 1, 4 -1, 5 2, 6 -2, 7 inf, 8 -inf, 9 qNaN, 10 sNaN
    function automatic logic [31:0] sv_(input int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h8000_0000;
            2: return 32'h0000_0001;  3: return 32'h3F80_0000;
            4: return 32'hBF80_0000;  5: return 32'h4000_0000;
            6: return 32'hC000_0000;  7: return 32'h7F80_0000;
            8: return 32'hFF80_0000;  9: return 32'h7FC0_0000;
            default: return 32'h7F80_0001;
        endcase
    endfunction

    function automatic logic [63:0] dv_(input int i);
        case (i)
            0: return 64'h0;                      1: return 64'h8000_0000_0000_0000;
            2: return 64'h1;                      3: return 64'h3FF0_0000_0000_0000;
            4: return 64'hBFF0_0000_0000_0000;    5: return 64'h4000_0000_0000_0000;
            6: return 64'hC000_0000_0000_0000;    7: return 64'h7FF0_0000_0000_0000;
            8: return 64'hFFF0_0000_0000_0000;    9: return 64'h7FF8_0000_0000_0000;
            default: return 64'h7FF0_0000_0000_0001;
        endcase
    endfunction

    function automatic int rank(input int i);
        case (i)
            0, 1: return 0;  2: return 1;  3: return 2;  4: return -2;
            5: return 3;     6: return -3; 7: return 4;  8: return -4;
            default: return 99;
        endcase
    endfunction

    // apply one lane's effect to an expected register value
    function automatic logic [31:0] lane_fx(input logic [31:0] f, input int ia, input int ib,
                                            input logic [2:0] p, input logic s, input logic [2:0] cc);
        logic [31:0] r = f;
        bit nan = (ia >= 9) || (ib >= 9);
        bit qn  = (ia == 9) || (ib == 9);
        bit c;
        int pos;
        if (s && qn) begin
            r[16] = 1'b1;
            r[6]  = 1'b1;
        end else begin
            if (nan) c = p[2];
            else     c = (p[1] && rank(ia) == rank(ib)) || (p[0] && rank(ia) < rank(ib));
            pos = (cc == 3'd0) ? 23 : 24 + int'(cc);
            r[pos] = c;
        end
        return r;
    endfunction

    function automatic string tag_of(input int ia, input int ib, input logic s);
        if (s && (ia == 9 || ib == 9)) return "R6";
        if (ia >= 9 || ib >= 9)        return "R5";
        return "R4";
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic csr_load(input logic [31:0] v);
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = v;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] f, input logic [2:0] p, input logic s,
                          input logic [2:0] cc, input logic [63:0] a, input logic [63:0] b,
                          input logic [31:0] init, input logic [31:0] exp, input string tag);
        csr_load(init);
        op_fmt = f; op_pred = p; op_sig = s; op_cc = cc; op_a = a; op_b = b;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        check(op_done === 1'b1 && csr_rdata === exp, tag, csr_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int k = 0;
        logic [31:0] init, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(csr_rdata === 32'h0 && op_done === 1'b0, "R1", csr_rdata, 32'h0);

        // R10 plain register load
        csr_load(32'h1234_5678);
        check(csr_rdata === 32'h1234_5678, "R10", csr_rdata, 32'h1234_5678);

        // R7 each condition index, 1.0 == 1.0 with equal predicate
        for (int c = 0; c < 8; c++) begin
            e = (c == 0) ? 32'h0080_0000 : (32'h1 << (24 + c));
            run_op(2'd0, 3'b010, 1'b0, 3'(c), 64'h3F80_0000, 64'h3F80_0000, 32'h0, e, "R7");
        end

        // R8 upper half junk in single, 1.0 < 2.0
        run_op(2'd0, 3'b001, 1'b0, 3'd0, 64'h7FF8_0000_3F80_0000, 64'hFFFF_FFFF_4000_0000,
               32'h0, 32'h0080_0000, "R8");
        // R8 reserved format only clears the cause field
        run_op(2'd3, 3'b111, 1'b1, 3'd2, 64'h0, 64'h0, 32'h0F83_F0FF, 32'h0F80_00FF, "R8");
        // R3 cause cleared, other bits kept
        run_op(2'd1, 3'b000, 1'b0, 3'd1, dv_(3), dv_(5), 32'hF07F_FFFF, 32'hF07C_0FFF, "R3");

        // sweeps in single and double
        for (int f = 0; f < 2; f++)
            for (int i = 0; i < 11; i++)
                for (int j = 0; j < 11; j++)
                    for (int p = 0; p < 8; p++)
                        for (int s = 0; s < 2; s++) begin
                            logic [2:0] cc = 3'((i + j + p) % 8);
                            logic [63:0] a, b;
                            k++;
                            init = 32'(k) * 32'h9E37_79B9;
                            e = init; e[17:12] = '0;
                            e = lane_fx(e, i, j, 3'(p), s[0], cc);
                            if (f == 0) begin
                                a = {32'hFFF8_1234 ^ 32'(i), sv_(i)};
                                b = {32'h7FC0_0000 + 32'(j), sv_(j)};
                            end else begin
                                a = dv_(i); b = dv_(j);
                            end
                            run_op(2'(f), 3'(p), s[0], cc, a, b, init, e, tag_of(i, j, s[0]));
                        end

        // R9 paired-single sweep
        for (int i = 0; i < 11; i++)
            for (int j = 0; j < 11; j++) begin
                int i1 = j, j1 = (i + 3) % 11;
                logic [2:0] p = 3'((i + j) % 8);
                logic s = 1'((i ^ j) & 1);
                logic [2:0] cc = 3'((i + 2 * j) % 8);
                k++;
                init = 32'(k) * 32'h85EB_CA6B;
                e = init; e[17:12] = '0;
                e = lane_fx(e, i, j, p, s, cc);
                e = lane_fx(e, i1, j1, p, s, cc + 3'd1);
                run_op(2'd2, p, s, cc, {sv_(i1), sv_(i)}, {sv_(j1), sv_(j)}, init, e, "R9");
            end

        // R10 commit wins over a register write; R2 strobe during COMMIT ignored
        csr_load(32'h0000_0000);
        op_fmt = 2'd0; op_pred = 3'b010; op_sig = 1'b0; op_cc = 3'd3;
        op_a = 64'h3F80_0000; op_b = 64'h3F80_0000;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b1; op_cc = 3'd5;
        csr_we = 1'b1; csr_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        op_valid = 1'b0; csr_we = 1'b0;
        check(op_done === 1'b1 && csr_rdata === 32'h0800_0000, "R10", csr_rdata, 32'h0800_0000);
        @(negedge clk);
        check(op_done === 1'b0 && csr_rdata === 32'h0800_0000, "R2", csr_rdata, 32'h0800_0000);
        @(negedge clk);
        check(op_done === 1'b0 && csr_rdata === 32'h0800_0000, "R2", csr_rdata, 32'h0800_0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule